// File: doc/BRIEF.md
# Block-Transfer Sequencer

This block turns one multi-register memory transfer command into a series of single-word accesses. A command carries a register bitmap, a base address and five mode bits: direction (`cmd_up`), pre-index (`cmd_pre`), base update (`cmd_wb`), load versus store (`cmd_load`) and a privileged flag (`cmd_priv`). The sequencer accepts the command while it is idle and keeps its own copy of the base address. It then walks the bitmap from the lowest register number to the highest, presenting one address and one register index per step on a valid/ready request port.

When the last access has been taken, the block can present the updated base value for one cycle. It also raises a single-cycle strobe when a privileged load brings in the program counter, so that the surrounding core can restore its status word. The memory, the register file banks and the status registers sit outside the block. Register-bank redirection and the exception-return form are signalled on plain output lines.

Top module: `blk_xfer_seq`

## Requirements
- R1: A command is taken on a cycle where `cmd_valid` is high and `busy` is low. A non-empty bitmap gives exactly as many requests as it has set bits, and `busy` then returns low.
- R2: The base address is captured when the command is taken. Changes on `cmd_base` after that point have no effect on any address or on the updated base value.
- R3: Each set bit of the bitmap is visited once, in rising register-index order, and its index appears on `req_reg`.
- R4: For transfer k (k = 0 to n-1) of an n-bit bitmap, the address is: base+4k (up, post); base+4k+4 (up, pre); base-4(n-1)+4k (down, post); base-4n+4k (down, pre).
- R5: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_reg` hold their values.
- R6: With `cmd_wb` set, `wb_valid` is high for exactly one cycle after the last accepted request, and `wb_value` is base+4n (up) or base-4n (down). With `cmd_wb` clear, `wb_valid` stays low.
- R7: `done` is high for exactly one cycle per non-empty command. It is high on the handshake of the last request when there is no base update, and it is high with `wb_valid` when there is one.
- R8: When `cmd_priv` and `cmd_load` are both set and bit 15 (the program counter) is in the bitmap, `eret_pulse` is high on the handshake cycle of the register-15 request only. `req_user` is low for that command.
- R9: When `cmd_priv` is set and bit 15 is absent, `req_user` is high on every request. When `cmd_priv` is clear, or when bit 15 is present, `req_user` is low.
- R10: An all-zero bitmap is refused. `err` is high for one cycle on the cycle after the command is offered, no request is issued, and `busy` stays low.
- R11: `req_load` equals the `cmd_load` bit of the command being executed, on every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_list | input | 16 | Register bitmap; bit 15 is the program counter |
| cmd_base | input | 32 | Base address |
| cmd_up | input | 1 | 1 = ascending addresses from the base, 0 = descending |
| cmd_pre | input | 1 | Pre-index: shift the whole window by one word |
| cmd_wb | input | 1 | Produce an updated base value at the end |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_priv | input | 1 | Privileged form (user bank or exception return) |
| busy | output | 1 | A command is in progress |
| req_valid | output | 1 | Memory request present |
| req_ready | input | 1 | Memory request taken |
| req_addr | output | 32 | Word address of the request |
| req_reg | output | 4 | Register index of the request |
| req_load | output | 1 | Request is a load |
| req_user | output | 1 | Register index refers to the user bank |
| eret_pulse | output | 1 | Program counter loaded in the exception-return form |
| wb_valid | output | 1 | Updated base value present |
| wb_value | output | 32 | Updated base value |
| done | output | 1 | Final step of the command |
| err | output | 1 | Empty bitmap refused |

## Verification
The assertions assume that the memory side raises `req_ready` only in answer to `req_valid`. They also assume that no command is offered on a cycle where a previous one is still running, so the address-step and index-order properties compare neighbouring steps of a single command. The bench drives every command from idle and waits for `busy` to fall before it offers the next one. It holds `req_ready` low except during deliberate handshakes, and it inserts stalls only where request stability is being examined.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WB   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lsb_pick.sv
module lsb_pick #(
    parameter int W = 16,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the top so that the lowest set bit is the last write.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pop_count.sv
module pop_count #(
    parameter int W = 16,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CNT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int LIST_W     = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [LIST_W-1:0]         cmd_list,
    input  logic [AW-1:0]             cmd_base,
    input  logic                      cmd_up,
    input  logic                      cmd_pre,
    input  logic                      cmd_wb,
    input  logic                      cmd_load,
    input  logic                      cmd_priv,
    output logic                      busy,
    output logic                      req_valid,
    input  logic                      req_ready,
    output logic [AW-1:0]             req_addr,
    output logic [$clog2(LIST_W)-1:0] req_reg,
    output logic                      req_load,
    output logic                      req_user,
    output logic                      eret_pulse,
    output logic                      wb_valid,
    output logic [AW-1:0]             wb_value,
    output logic                      done,
    output logic                      err
);
    localparam int IDX_W  = $clog2(LIST_W);
    localparam int CNT_W  = $clog2(LIST_W + 1);
    localparam int PC_IDX = LIST_W - 1;
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    typedef struct packed {
        seq_state_e        st;
        logic [LIST_W-1:0] list;
        logic [AW-1:0]     base;
        logic [AW-1:0]     off;
        logic [CNT_W-1:0]  cnt;
        logic              up;
        logic              wb;
        logic              load;
        logic              user;
        logic              eret_ok;
        logic              err;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [CNT_W-1:0] cmd_cnt;
    logic [IDX_W-1:0] cur_idx;
    logic             cur_any;
    logic             last_step;
    logic             hs;
    logic [AW-1:0]    span;
    logic [AW-1:0]    first_off;
    logic             pc_in_cmd;

    pop_count #(.W(LIST_W)) u_pop (.vec(cmd_list), .cnt(cmd_cnt));
    lsb_pick  #(.W(LIST_W)) u_pick (.vec(r_q.list), .idx(cur_idx), .any(cur_any));

    assign pc_in_cmd = cmd_list[PC_IDX];
    assign span      = AW'(cmd_cnt) * STEP;

    // Starting offset: up begins at zero, down at the far end of the window.
    always_comb begin
        first_off = cmd_up ? '0 : (span - STEP);
        if (cmd_pre) first_off = first_off + STEP;
    end

    assign last_step = cur_any && ((r_q.list & (r_q.list - LIST_W'(1))) == '0);
    assign hs        = req_valid && req_ready;

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_list == '0) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st      = ST_XFER;
                        r_d.list    = cmd_list;
                        r_d.base    = cmd_base;
                        r_d.off     = first_off;
                        r_d.cnt     = cmd_cnt;
                        r_d.up      = cmd_up;
                        r_d.wb      = cmd_wb;
                        r_d.load    = cmd_load;
                        r_d.user    = cmd_priv && !pc_in_cmd;
                        r_d.eret_ok = cmd_priv && cmd_load && pc_in_cmd;
                    end
                end
            end
            ST_XFER: begin
                if (req_ready) begin
                    r_d.list[cur_idx] = 1'b0;
                    r_d.off = r_q.up ? (r_q.off + STEP) : (r_q.off - STEP);
                    if (last_step) r_d.st = r_q.wb ? ST_WB : ST_IDLE;
                end
            end
            ST_WB:   r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign req_valid  = (r_q.st == ST_XFER);
    assign req_addr   = r_q.up ? (r_q.base + r_q.off) : (r_q.base - r_q.off);
    assign req_reg    = cur_idx;
    assign req_load   = r_q.load;
    assign req_user   = r_q.user;
    assign eret_pulse = hs && r_q.eret_ok && (cur_idx == IDX_W'(PC_IDX));
    assign wb_valid   = (r_q.st == ST_WB);
    assign wb_value   = r_q.up ? (r_q.base + AW'(r_q.cnt) * STEP)
                               : (r_q.base - AW'(r_q.cnt) * STEP);
    assign done       = (hs && last_step && !r_q.wb) || wb_valid;
    assign err        = r_q.err;

    // Stalled requests keep their payload (R5).
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_reg));

    // Next visited register has a higher index (R3).
    p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs && ($countones(r_q.list) > 1) |=> req_valid && (req_reg > $past(req_reg)));

    // Neighbouring transfers are one word apart in every mode (R4).
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hs && ($countones(r_q.list) > 1) |=> req_addr == $past(req_addr) + STEP);

    // Empty bitmap is refused without starting (R10).
    p_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && (cmd_list == '0) |=> err && !busy && !req_valid);

    // Updated base lasts one cycle (R6).
    p_wb_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid && !busy);
endmodule

// File: tb/tb_blk_xfer_seq.sv
module tb_blk_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_list = '0;
    logic [31:0] cmd_base = '0;
    logic        cmd_up = 1'b0, cmd_pre = 1'b0, cmd_wb = 1'b0, cmd_load = 1'b0, cmd_priv = 1'b0;
    logic        busy, req_valid, req_ready, req_load, req_user, eret_pulse;
    logic        wb_valid, done, err;
    logic [31:0] req_addr, wb_value;
    logic [3:0]  req_reg;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    blk_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_list(cmd_list),
        .cmd_base(cmd_base), .cmd_up(cmd_up), .cmd_pre(cmd_pre), .cmd_wb(cmd_wb),
        .cmd_load(cmd_load), .cmd_priv(cmd_priv), .busy(busy), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_reg(req_reg),
        .req_load(req_load), .req_user(req_user), .eret_pulse(eret_pulse),
        .wb_valid(wb_valid), .wb_value(wb_value), .done(done), .err(err)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Run one command; every request is compared against values computed here.
    task automatic run_cmd(input logic [15:0] lst, input logic [31:0] base,
                           input logic up, input logic pre, input logic wb,
                           input logic ld, input logic pv, input logic stall);
        int n = 0;
        int k = 0;
        int bit_i = 0;
        logic [31:0] first, exp_a, hold_a;
        logic [3:0]  hold_r;
        logic exp_user, exp_eret;
        for (int i = 0; i < 16; i++) n += int'(lst[i]);
        if (up) first = base + (pre ? 32'd4 : 32'd0);
        else    first = base - 32'(4 * n) + (pre ? 32'd0 : 32'd4);
        exp_user = pv && !lst[15];
        @(negedge clk);
        cmd_list = lst; cmd_base = base; cmd_up = up; cmd_pre = pre;
        cmd_wb = wb; cmd_load = ld; cmd_priv = pv; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_base = ~base;  // R2: must not matter any more
        for (k = 0; k < n; k++) begin
            while (!lst[bit_i]) bit_i++;
            exp_a = first + 32'(4 * k);
            if (stall) begin
                hold_a = req_addr; hold_r = req_reg;
                @(negedge clk);
                chk(req_valid && req_addr == hold_a && req_reg == hold_r,
                    "R5 stalled request held", req_addr, hold_a);
            end
            chk(req_valid, "R1 request present", 32'(req_valid), 32'd1);
            chk(req_addr == exp_a, "R4/R2 address", req_addr, exp_a);
            chk(req_reg == 4'(bit_i), "R3 register order", 32'(req_reg), 32'(bit_i));
            chk(req_user == exp_user, "R9 user bank", 32'(req_user), 32'(exp_user));
            chk(req_load == ld, "R11 load flag", 32'(req_load), 32'(ld));
            req_ready = 1'b1;
            #1;
            exp_eret = pv && ld && (bit_i == 15);
            chk(eret_pulse == exp_eret, "R8 exception return strobe", 32'(eret_pulse), 32'(exp_eret));
            chk(done == ((k == n - 1) && !wb), "R7 done on handshake", 32'(done), 32'((k == n - 1) && !wb));
            @(negedge clk);
            req_ready = 1'b0;
            bit_i++;
        end
        if (wb) begin
            chk(wb_valid && done, "R6/R7 update step with done", {30'd0, wb_valid, done}, 32'd3);
            exp_a = up ? base + 32'(4 * n) : base - 32'(4 * n);
            chk(wb_value == exp_a, "R6/R2 updated base", wb_value, exp_a);
            @(negedge clk);
        end
        chk(!busy && !wb_valid && !req_valid && !done, "R1/R6 back to idle",
            {28'd0, busy, wb_valid, req_valid, done}, 32'd0);
    endtask

    task automatic t_reset();
        chk(!busy && !req_valid && !wb_valid && !done && !err && !eret_pulse,
            "R1 reset state", {26'd0, busy, req_valid, wb_valid, done, err, eret_pulse}, 32'd0);
    endtask
    task automatic t_up_post_load();  run_cmd(16'h00F1, 32'h0000_1000, 1, 0, 0, 1, 0, 0); endtask
    task automatic t_up_pre_store();  run_cmd(16'h0A06, 32'h0000_2000, 1, 1, 1, 0, 0, 1); endtask
    task automatic t_down_post_wb();  run_cmd(16'h0390, 32'h0000_3000, 0, 0, 1, 1, 0, 0); endtask
    task automatic t_down_pre();      run_cmd(16'h1023, 32'h0000_4000, 0, 1, 0, 0, 0, 1); endtask
    task automatic t_eret_load();     run_cmd(16'h8011, 32'h0000_5000, 1, 0, 1, 1, 1, 0); endtask
    task automatic t_user_store();    run_cmd(16'h00C3, 32'h0000_6000, 0, 1, 0, 0, 1, 0); endtask
    task automatic t_priv_store_pc(); run_cmd(16'h8002, 32'h0000_7000, 1, 1, 0, 0, 1, 0); endtask
    task automatic t_single_pc();     run_cmd(16'h8000, 32'h0000_8000, 1, 0, 1, 1, 0, 0); endtask
    task automatic t_full_down();     run_cmd(16'hFFFF, 32'h0000_9000, 0, 1, 1, 1, 1, 0); endtask

    task automatic t_empty();
        @(negedge clk);
        cmd_list = '0; cmd_valid = 1'b1; cmd_load = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(err && !busy && !req_valid, "R10 empty refused",
            {29'd0, err, busy, req_valid}, 32'h4);
        @(negedge clk);
        chk(!err && !busy && !req_valid && !done, "R10 single error pulse",
            {28'd0, err, busy, req_valid, done}, 32'd0);
    endtask

    initial begin
        req_ready = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up_post_load();
        t_up_pre_store();
        t_down_post_wb();
        t_down_pre();
        t_eret_load();
        t_user_store();
        t_priv_store_pc();
        t_empty();
        t_single_pc();
        t_full_down();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule